// File: doc/BRIEF.md
# Programmable Run-Length Violation Detector

This block sits on the recovered parallel data path of a serial receiver. It watches the stream one bit at a time and tracks how many identical bits have arrived in a row. Words arrive once per recovered clock, and the earliest bit of each word is bit 0. A run that spans several words is counted as one run. When the current run grows longer than a threshold given on an input, the block raises a violation flag. The flag is held high for at least two clock cycles, so that logic downstream can sample it reliably.

A parameter selects the word width: either 8-bit or 10-bit serialization. Each width has its own ceiling on the threshold, 128 bit times for 8-bit words and 160 for 10-bit words. Any larger threshold value is treated as the ceiling. The block does no alignment and no decoding, and it counts no errors. Its only output is the flag.

Top module: `rlv_run_monitor`

## Requirements
- R1: Bits are taken in order from bit 0 to the top bit of each word, and a run continues from one word into the next. A bit equal to the previous bit lengthens the run by one. A bit that differs from it starts a new run of length 1.
- R2: A violation is detected when the run length at any bit of a word is strictly greater than the effective threshold. The flag is high in the cycle after the clock edge that captures that word.
- R3: A single violation keeps the flag high for exactly two cycles when no further violation follows.
- R4: The effective threshold is the smaller of thresholdIn and the mode ceiling. The ceiling is 128 in 8-bit mode and 160 in 10-bit mode.
- R5: The run counter saturates at 255 and never wraps, so a run of any length keeps the flag high without a gap.
- R6: A violation that arrives while the flag is already high restarts the two-cycle hold window.
- R7: Parameter WIDE_MODE = 0 selects 8-bit words (wordIn[7:0] is used). WIDE_MODE = 1 selects 10-bit words.
- R8: Reset is asynchronous and active low. It clears the flag, sets the run length to 0 and sets the stored last bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered parallel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wordIn | input | 8 or 10 | Parallel data word; bit 0 is the earliest bit |
| thresholdIn | input | 8 | Run-length threshold in bit times |
| violation | output | 1 | Stretched run-length violation flag |

## Verification
A run counter that is wrong shows up as a violation flag that moves in time. The flag appears one cycle early or late when a run crosses the threshold, or it drops in the middle of a very long run. The bench feeds runs of exactly the threshold length and of one bit more, so an off-by-one error in counting, restarting or comparing is seen within one word of the deciding bit. A stretch counter that is wrong changes the width of the flag pulse, and that is seen within three cycles of any isolated or repeated violation.

// File: rtl/rlv_pkg.sv
package rlv_pkg;
  // Event strobe passed from the bit-scan datapath to the stretch control
  typedef struct packed {
    logic hit;   // some bit of this word pushed the run past the threshold
  } runEvent_t;

  // Threshold ceiling in bit times for each word width
  function automatic int unsigned modeCeiling(bit wideMode);
    return wideMode ? 160 : 128;
  endfunction
endpackage

// File: rtl/rlv_threshold_clamp.sv
module rlv_threshold_clamp #(
  parameter int CNT_W = 8,
  parameter int CEIL  = 160
) (
  input  logic [CNT_W-1:0] thrIn,
  output logic [CNT_W-1:0] thrEff
);
  localparam logic [CNT_W-1:0] CEIL_V = CNT_W'(CEIL);

  // R4: limit the threshold to the mode ceiling
  always_comb begin
    thrEff = (thrIn > CEIL_V) ? CEIL_V : thrIn;
  end
endmodule

// File: rtl/rlv_run_scan.sv
module rlv_run_scan
  import rlv_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordIn,
  input  logic [CNT_W-1:0]  thrEff,
  output runEvent_t         evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0]  runCnt;
  logic              lastBit;
  logic [CNT_W-1:0]  stCnt [0:WORD_W];
  logic              stBit [0:WORD_W];
  logic [WORD_W-1:0] stHit;

  assign stCnt[0] = runCnt;
  assign stBit[0] = lastBit;

  // One stage for each bit, starting at bit 0 (R1); each count saturates (R5)
  for (genvar g = 0; g < WORD_W; g++) begin : g_stage
    assign stCnt[g+1] = (wordIn[g] == stBit[g])
                        ? ((stCnt[g] == CNT_MAX) ? CNT_MAX : stCnt[g] + CNT_ONE)
                        : CNT_ONE;
    assign stBit[g+1] = wordIn[g];
    assign stHit[g]   = (stCnt[g+1] > thrEff);   // R2: strictly greater
  end

  assign evt.hit = |stHit;

  // R8: reset clears the count and the stored last bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt  <= '0;
      lastBit <= 1'b0;
    end else begin
      runCnt  <= stCnt[WORD_W];
      lastBit <= stBit[WORD_W];
    end
  end

  // R1: an all-ones word that follows a stored 0 leaves a run of exactly one word
  p_restart_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wordIn == {WORD_W{1'b1}} && !lastBit) |=> (runCnt == CNT_W'(WORD_W)));

  // R5: a word that continues the run never lowers the count
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wordIn == {WORD_W{lastBit}}) |=> (runCnt >= $past(runCnt)));
endmodule

// File: rtl/rlv_stretch_ctrl.sv
module rlv_stretch_ctrl
  import rlv_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  runEvent_t evt,
  output logic      violation
);
  localparam int HC_W = $clog2(HOLD_CYC + 1);
  localparam logic [HC_W-1:0] HOLD_V = HC_W'(HOLD_CYC);

  logic [HC_W-1:0] holdCnt;

  // R3/R6: load on every hit, then count down
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdCnt <= '0;
    else if (evt.hit)        holdCnt <= HOLD_V;
    else if (holdCnt != '0)  holdCnt <= holdCnt - HC_W'(1);
  end

  assign violation = (holdCnt != '0);

  // R2: a hit shows on the flag in the next cycle
  p_hit_flags_r2: assert property (@(posedge clk) disable iff (!rstN)
    evt.hit |=> violation);

  // R3: the flag never lasts a single cycle
  p_min_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(violation) |=> violation);

  // R6: a hit during the stretch reloads the full window
  p_retrigger_r6: assert property (@(posedge clk) disable iff (!rstN)
    (evt.hit && violation) |=> (holdCnt == HOLD_V));
endmodule

// File: rtl/rlv_run_monitor.sv
module rlv_run_monitor
  import rlv_pkg::*;
#(
  parameter bit WIDE_MODE = 1'b1,
  localparam int WORD_W   = WIDE_MODE ? 10 : 8,
  localparam int CEIL     = modeCeiling(WIDE_MODE),
  localparam int CNT_W    = $clog2(CEIL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordIn,
  input  logic [CNT_W-1:0]  thresholdIn,
  output logic              violation
);
  logic [CNT_W-1:0] thrEff;
  runEvent_t        evt;

  rlv_threshold_clamp #(.CNT_W(CNT_W), .CEIL(CEIL)) u_clamp (
    .thrIn (thresholdIn),
    .thrEff(thrEff)
  );

  rlv_run_scan #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_scan (
    .clk   (clk),
    .rstN  (rstN),
    .wordIn(wordIn),
    .thrEff(thrEff),
    .evt   (evt)
  );

  rlv_stretch_ctrl #(.HOLD_CYC(2)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .evt      (evt),
    .violation(violation)
  );
endmodule

// File: tb/rlv_run_monitor_tb.sv
module rlv_run_monitor_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN;
  logic [9:0] word10;
  logic [7:0] word8;
  logic [7:0] thr;
  logic       viol10, viol8;

  rlv_run_monitor #(.WIDE_MODE(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .wordIn(word10), .thresholdIn(thr), .violation(viol10));
  rlv_run_monitor #(.WIDE_MODE(1'b0)) u_dut8 (
    .clk(clk), .rstN(rstN), .wordIn(word8), .thresholdIn(thr), .violation(viol8));

  localparam logic [9:0] IDLE10 = 10'b0101010101;
  localparam logic [7:0] IDLE8  = 8'b01010101;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  string curReq = "R8";
  int thrCur = 0;
  // index 0: 8-bit unit, index 1: 10-bit unit
  int wBits[2] = '{8, 10};
  int ceilV[2] = '{128, 160};
  int mCnt[2], mLast[2], mHold[2];
  int fill[2];
  logic [9:0] acc[2];
  int lastPushed[2];

  task automatic modelReset();
    for (int m = 0; m < 2; m++) begin
      mCnt[m] = 0; mLast[m] = 0; mHold[m] = 0;
    end
  endtask

  task automatic applyWord(int m, logic [9:0] w);
    bit hit = 1'b0;
    int eff = (thrCur > ceilV[m]) ? ceilV[m] : thrCur;
    for (int i = 0; i < wBits[m]; i++) begin
      int b = int'(w[i]);
      if (b == mLast[m]) mCnt[m] = (mCnt[m] >= 255) ? 255 : mCnt[m] + 1;
      else               mCnt[m] = 1;
      mLast[m] = b;
      if (mCnt[m] > eff) hit = 1'b1;
    end
    mHold[m] = hit ? 2 : ((mHold[m] > 0) ? mHold[m] - 1 : 0);
  endtask

  task automatic checkOut();
    logic got[2];
    got[0] = viol8;
    got[1] = viol10;
    for (int m = 0; m < 2; m++) begin
      logic exp = (mHold[m] > 0);
      checks++;
      if (got[m] !== exp) begin
        errors++;
        $display("FAIL %s (%0d-bit): violation=%0b expected=%0b", curReq, wBits[m], got[m], exp);
      end
    end
  endtask

  task automatic tick(logic [9:0] w10, logic [7:0] w8);
    @(negedge clk);
    checkOut();
    thr = 8'(thrCur);
    word10 = w10;
    word8  = w8;
    applyWord(1, w10);
    applyWord(0, {2'b00, w8});
  endtask

  task automatic sendBit(int m, int b);
    acc[m][fill[m]] = b[0];
    lastPushed[m] = b;
    fill[m]++;
    if (fill[m] == wBits[m]) begin
      if (m == 1) tick(acc[1], IDLE8);
      else        tick(IDLE10, acc[0][7:0]);
      fill[m] = 0;
      acc[m] = '0;
    end
  endtask

  task automatic sendRun(int m, int b, int len);
    for (int i = 0; i < len; i++) sendBit(m, b);
  endtask

  task automatic flush(int m);
    while (fill[m] != 0) sendBit(m, 1 - lastPushed[m]);
  endtask

  task automatic doReset();
    @(negedge clk);
    checkOut();
    rstN = 1'b0;
    word10 = IDLE10;
    word8  = IDLE8;
    modelReset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkOut();
    end
    rstN = 1'b1;
    thr = 8'(thrCur);
    applyWord(1, IDLE10);
    applyWord(0, {2'b00, IDLE8});
  endtask

  initial begin
    rstN = 1'b0; word10 = IDLE10; word8 = IDLE8; thr = '0;
    fill = '{0, 0}; acc = '{'0, '0}; lastPushed = '{0, 0};
    modelReset();
    // R8: flag low out of reset
    curReq = "R8 reset state";
    thrCur = 9;
    doReset();
    sendRun(1, 0, 9); flush(1);
    sendRun(0, 0, 10); flush(0);

    // R1 R2 R7: threshold sweep, runs of exactly thr and thr+1 bits
    curReq = "R1 R2 R7 sweep 10-bit";
    for (int t = 0; t <= 175; t++) begin
      thrCur = t;
      sendRun(1, 1, t); sendRun(1, 0, t + 1); sendRun(1, 1, 2);
    end
    flush(1);
    curReq = "R1 R2 R7 sweep 8-bit";
    for (int t = 0; t <= 140; t++) begin
      thrCur = t;
      sendRun(0, 0, t + 1); sendRun(0, 1, t); sendRun(0, 0, 3);
    end
    flush(0);

    // R4: clamping at the mode ceiling
    curReq = "R4 clamp";
    thrCur = 255;
    sendRun(1, 1, 160); sendRun(1, 0, 161); sendRun(1, 1, 1); flush(1);
    sendRun(0, 0, 128); sendRun(0, 1, 129); sendRun(0, 0, 1); flush(0);
    thrCur = 200;
    sendRun(0, 1, 129); sendRun(0, 0, 2); flush(0);

    // R5: very long runs must not wrap the counter
    curReq = "R5 saturation";
    thrCur = 255;
    sendRun(1, 1, 700); flush(1);
    sendRun(0, 0, 700); flush(0);

    // R3: isolated violations give two-cycle pulses
    curReq = "R3 single stretch";
    thrCur = 12;
    for (int k = 0; k < 6; k++) begin
      sendRun(1, 1, 13);
      for (int j = 0; j < 40; j++) sendRun(1, j % 2, 1 + (j % 2));
      sendRun(0, 0, 13);
      for (int j = 0; j < 40; j++) sendRun(0, j % 2, 1 + (j % 2));
    end
    flush(1); flush(0);

    // R6: dense violations restart the window
    curReq = "R6 retrigger";
    thrCur = 3;
    for (int k = 0; k < 60; k++) begin
      sendRun(1, 1, 4 + (k % 3)); sendRun(1, 0, 1 + (k % 7));
      sendRun(0, 0, 4 + (k % 5)); sendRun(0, 1, 1 + (k % 9));
    end
    flush(1); flush(0);

    // R8: reset during activity clears flag, count and last bit
    curReq = "R8 mid-run reset";
    thrCur = 2;
    sendRun(1, 1, 20);
    thrCur = 9;
    sendRun(1, 0, 8);
    flush(1);
    doReset();
    sendRun(1, 0, 10); sendRun(1, 1, 3); flush(1);
    for (int i = 0; i < 4; i++) tick(IDLE10, IDLE8);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule